// File: doc/BRIEF.md
# Residue-to-Binary Reverse Converter

This block turns a number held as four residues back into ordinary binary. The four moduli are 2^N, 2^N−1, 2^(N+1)−1 and 2^(N−1)−1, with an even N of at least 4. The result is the one integer X in [0, M) whose residues match the inputs, where M is the product of the four moduli. With the default N = 4 the moduli are 16, 15, 31 and 7, and M is 52080.

The conversion works through mixed-radix digits. The first digit is the residue modulo 2^N, taken as it is. The remaining three digits are computed with modular adders that add their carry-out back into the sum. Each modular subtraction adds the bitwise complement of the operand. Each multiplication by a modular inverse is a fixed bit rotation, or a short sum of rotations in the case of the inverse of 3 modulo 2^(N−1)−1. A shift-and-subtract stage then weighs the digits into the binary result. The block has no registers and no lookup tables, so the output follows the inputs after combinational delay only.

Top module: `rns_rev_conv`

## Requirements
- R1: For in-range inputs, value_out modulo 2^N equals in_pow2.
- R2: For in-range inputs, value_out modulo 2^N−1 equals in_pm1.
- R3: For in-range inputs, value_out modulo 2^(N+1)−1 equals in_wide.
- R4: For in-range inputs, value_out modulo 2^(N−1)−1 equals in_narrow.
- R5: value_out is always below M, the product of the four moduli.
- R6: A modular difference of zero is always delivered as all-zero bits, never as the all-ones pattern. Every mixed-radix digit lies below its modulus. The case where all four residues are equal (any X below 7 when N = 4) converts exactly.
- R7: The block has no clock and no latency: value_out follows a change at the inputs without any clock edge.
- R8: Every X in [0, M), presented as its four residues, converts back to exactly X.
- R9: Input widths are N, N, N+1 and N−1 bits. The output width is the bit count of M−1, which is 16 bits for N = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_pow2 | input | N | Residue modulo 2^N; also the first mixed-radix digit |
| in_pm1 | input | N | Residue modulo 2^N−1 |
| in_wide | input | N+1 | Residue modulo 2^(N+1)−1 |
| in_narrow | input | N−1 | Residue modulo 2^(N−1)−1 |
| value_out | output | XW | Reconstructed binary integer, XW = bit count of M−1 |

## Verification
The assertions assume that each residue is strictly below its modulus. In particular, no input may be all ones on the three 2^k−1 channels, because that pattern is a second code for zero and lies outside the contract. The checker therefore evaluates the residue and digit properties only when all three of those inputs are below their moduli. The stimulus derives every input with the remainder operator from an integer in [0, M), so every applied tuple is legal. It covers the whole dynamic range for N = 4.

// File: rtl/rns_pkg.sv
package rns_pkg;

    // Product of the four moduli for a given N.
    function automatic longint unsigned span(input int n);
        longint unsigned p2;
        p2 = longint'(1) << n;
        return p2 * (p2 - 1) * (2 * p2 - 1) * (p2 / 2 - 1);
    endfunction

    // Bits needed to hold any value in [0, v).
    function automatic int bits_for(input longint unsigned v);
        int b;
        b = 0;
        for (int i = 0; i < 63; i++) begin
            if ((longint'(1) << i) < v) b = i + 1;
        end
        return b;
    endfunction

endpackage

// File: rtl/rns_modadd.sv
// Adder modulo 2^K-1 with end-around carry; result normalised so that
// the all-ones code for zero never leaves the adder.
module rns_modadd #(
    parameter int K = 4
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    output logic [K-1:0] s
);
    logic [K:0]   raw;
    logic [K-1:0] wrap;

    assign raw  = {1'b0, a} + {1'b0, b};
    assign wrap = raw[K-1:0] + {{(K-1){1'b0}}, raw[K]};
    assign s    = (&wrap) ? '0 : wrap;
endmodule

// File: rtl/rns_mrc_digits.sv
// Mixed-radix digits 2..4 from the residues.
module rns_mrc_digits #(
    parameter int N = 4
) (
    input  logic [N-1:0] r1,
    input  logic [N-1:0] r2,
    input  logic [N:0]   r3,
    input  logic [N-2:0] r4,
    output logic [N-1:0] d2,
    output logic [N:0]   d3,
    output logic [N-2:0] d4
);
    localparam int KB = N + 1;
    localparam int KC = N - 1;
    localparam int NT = (KC + 1) / 2;

    // digit 2: (r2 - r1) mod 2^N-1, since 2^N == 1 there
    rns_modadd #(.K(N)) u_d2 (.a(r2), .b(~r1), .s(d2));

    // digit 3: 2 * (d2 - 2 * (r3 - r1)) mod 2^(N+1)-1
    logic [KB-1:0] a3, b3, c3;
    rns_modadd #(.K(KB)) u_a3 (.a(r3), .b(~{1'b0, r1}), .s(a3));
    assign b3 = {a3[KB-2:0], a3[KB-1]};
    rns_modadd #(.K(KB)) u_c3 (.a({1'b0, d2}), .b(~b3), .s(c3));
    assign d3 = {c3[KB-2:0], c3[KB-1]};

    // fold earlier digits into the narrow channel (2^KC == 1)
    logic [KC-1:0] f1, f2, f3;
    rns_modadd #(.K(KC)) u_f1 (.a(r1[KC-1:0]), .b({{(KC-1){1'b0}}, r1[N-1]}), .s(f1));
    rns_modadd #(.K(KC)) u_f2 (.a(d2[KC-1:0]), .b({{(KC-1){1'b0}}, d2[N-1]}), .s(f2));
    rns_modadd #(.K(KC)) u_f3 (.a(d3[KC-1:0]), .b({{(KC-2){1'b0}}, d3[N:N-1]}), .s(f3));

    // digit 4: ((r4 - d1) / 2 - d2 - d3) * inv(3) mod 2^(N-1)-1
    logic [KC-1:0] e1, e2, e3, e4;
    rns_modadd #(.K(KC)) u_e1 (.a(r4), .b(~f1), .s(e1));
    assign e2 = {e1[0], e1[KC-1:1]};
    rns_modadd #(.K(KC)) u_e3 (.a(e2), .b(~f2), .s(e3));
    rns_modadd #(.K(KC)) u_e4 (.a(e3), .b(~f3), .s(e4));

    // inverse of 3 is (2^(KC+1)-1)/3 = sum of 2^(2j): rotations by even counts
    logic [KC-1:0] acc [NT];
    assign acc[0] = e4;
    for (genvar j = 1; j < NT; j++) begin : g_inv
        logic [KC-1:0] rot;
        assign rot = {e4[KC-1-2*j:0], e4[KC-1:KC-2*j]};
        rns_modadd #(.K(KC)) u_acc (.a(acc[j-1]), .b(rot), .s(acc[j]));
    end
    assign d4 = acc[NT-1];
endmodule

// File: rtl/rns_mr_weigh.sv
// X = d1 + 2^N * (d2 + m2 * (d3 + m3 * d4)) by shift-and-subtract.
module rns_mr_weigh #(
    parameter int N  = 4,
    parameter int XW = 16
) (
    input  logic [N-1:0]  d1,
    input  logic [N-1:0]  d2,
    input  logic [N:0]    d3,
    input  logic [N-2:0]  d4,
    output logic [XW-1:0] x
);
    logic [XW-1:0] w4, y3, y2;

    assign w4 = XW'(d4);
    assign y3 = XW'(d3) + (w4 << (N + 1)) - w4;
    assign y2 = XW'(d2) + (y3 << N) - y3;
    assign x  = XW'({y2, d1});
endmodule

// File: rtl/rns_rev_conv.sv
module rns_rev_conv #(
    parameter  int N  = 4,
    localparam int XW = rns_pkg::bits_for(rns_pkg::span(N))
) (
    input  logic [N-1:0]  in_pow2,
    input  logic [N-1:0]  in_pm1,
    input  logic [N:0]    in_wide,
    input  logic [N-2:0]  in_narrow,
    output logic [XW-1:0] value_out
);
    logic [N-1:0] dig2;
    logic [N:0]   dig3;
    logic [N-2:0] dig4;

    rns_mrc_digits #(.N(N)) u_dig (
        .r1(in_pow2), .r2(in_pm1), .r3(in_wide), .r4(in_narrow),
        .d2(dig2), .d3(dig3), .d4(dig4)
    );

    rns_mr_weigh #(.N(N), .XW(XW)) u_wgt (
        .d1(in_pow2), .d2(dig2), .d3(dig3), .d4(dig4), .x(value_out)
    );
endmodule

// File: rtl/rns_rev_conv_chk.sv
module rns_rev_conv_chk #(
    parameter int N = 4
) (
    input logic [N-1:0] in_pow2,
    input logic [N-1:0] in_pm1,
    input logic [N:0]   in_wide,
    input logic [N-2:0] in_narrow,
    input logic [rns_pkg::bits_for(rns_pkg::span(N))-1:0] value_out,
    input logic [N-1:0] dig2,
    input logic [N:0]   dig3,
    input logic [N-2:0] dig4
);
    localparam longint unsigned M1 = longint'(1) << N;
    localparam longint unsigned M2 = M1 - 1;
    localparam longint unsigned M3 = 2 * M1 - 1;
    localparam longint unsigned M4 = M1 / 2 - 1;
    localparam longint unsigned MT = rns_pkg::span(N);

    logic legal;
    longint unsigned v;

    always_comb begin
        legal = !(&in_pm1) && !(&in_wide) && !(&in_narrow);
        v     = longint'(value_out);
        if (legal) begin
            // R1
            res_pow2_chk: assert (v % M1 == longint'(in_pow2));
            // R2
            res_pm1_chk: assert (v % M2 == longint'(in_pm1));
            // R3
            res_wide_chk: assert (v % M3 == longint'(in_wide));
            // R4
            res_narrow_chk: assert (v % M4 == longint'(in_narrow));
            // R5
            out_range_chk: assert (v < MT);
            // R6
            digit_norm_chk: assert (longint'(dig2) < M2 && longint'(dig3) < M3
                                    && longint'(dig4) < M4);
        end
    end
endmodule

bind rns_rev_conv rns_rev_conv_chk #(.N(N)) u_chk (
    .in_pow2(in_pow2), .in_pm1(in_pm1), .in_wide(in_wide), .in_narrow(in_narrow),
    .value_out(value_out), .dig2(dig2), .dig3(dig3), .dig4(dig4)
);

// File: tb/sim_rns_rev_conv.sv
module sim_rns_rev_conv;
    localparam int N    = 4;
    localparam int M1   = 1 << N;
    localparam int M2   = M1 - 1;
    localparam int M3   = 2 * M1 - 1;
    localparam int M4   = M1 / 2 - 1;
    localparam int MTOT = M1 * M2 * M3 * M4;
    localparam int XW   = rns_pkg::bits_for(rns_pkg::span(N));

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]  a_p2, a_m1;
    logic [N:0]    a_w;
    logic [N-2:0]  a_n;
    logic [XW-1:0] y;

    int n_chk  = 0;
    int n_fail = 0;

    rns_rev_conv #(.N(N)) u0 (
        .in_pow2(a_p2), .in_pm1(a_m1), .in_wide(a_w), .in_narrow(a_n),
        .value_out(y)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input int x);
        a_p2 = N'(x % M1);
        a_m1 = N'(x % M2);
        a_w  = (N+1)'(x % M3);
        a_n  = (N-1)'(x % M4);
    endtask

    initial begin
        apply(0);
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R9: port widths, output is bit count of 52079
        check("R9", $bits(y), 16);
        check("R9", $bits(a_w), N + 1);
        check("R9", $bits(a_n), N - 1);

        // R6: all-zero tuple gives zero
        @(negedge clk);
        apply(0);
        #2 check("R6", y, 0);

        // R7: output follows inputs with no clock edge in between
        @(negedge clk);
        apply(MTOT - 1);
        #1 check("R7", y, MTOT - 1);
        apply(1);
        #1 check("R7", y, 1);

        // R1..R8: every value of the dynamic range
        for (int x = 0; x < MTOT; x++) begin
            @(negedge clk);
            apply(x);
            #2;
            if (x < M4) check("R6", y, x);
            else        check("R8", y, x);
            check("R1", y % M1, a_p2);
            check("R2", y % M2, a_m1);
            check("R3", y % M3, a_w);
            check("R4", y % M4, a_n);
            check("R5", (y < MTOT) ? 1 : 0, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule